// File: doc/BRIEF.md
# Demand-Driven Transfer Bus Handshake Controller

This block sits on the controller side of a shared 64-bit data bus. An external device uses it to get the data bus released and to raise DMA transfer requests. The device drives two active-low strobes, a bus-release request and a transfer-request strobe, and can place a request descriptor on the data bus. The controller answers with a one-cycle, active-low bus-available pulse. The bus is released two cycles after that pulse. Around the release cycle, the controller removes the enable from its own data-pin drivers for three cycles.

Every transfer-request strobe is decoded into a single-cycle request event. The event carries a channel number and a kind code. What the strobe means depends on when it arrives:

- In the release cycle, it carries a descriptor from the data bus.
- Together with a release request, it is a direct request for a fixed channel.
- On its own, it repeats the request for the channel requested most recently.

The DMA engine consumes these events.

A state machine tracks the release sequence through five states:

- `ST_IDLE`: waiting for a release request.
- `ST_GRANT`: bus-available is asserted.
- `ST_PRE`: the blanking cycle before the release.
- `ST_RELEASE`: the cycle in which the bus is released.
- `ST_POST`: the blanking cycle after the release.

The transitions are:

- `ST_IDLE` to `ST_GRANT` when a release request is sampled without the strobe.
- `ST_GRANT` to `ST_PRE` to `ST_RELEASE` to `ST_POST` unconditionally.
- `ST_POST` back to `ST_IDLE`.

Top module: `ddt_bus_handshake`

## Requirements
- R1: While reset (rst_n low) is active, bus_avail_n is 1, data_oe is 1 and evt_valid is 0. After reset the remembered channel is 0.
- R2: A release request (rel_req_n low with xfer_req_n high) sampled at a rising edge in `ST_IDLE` drives bus_avail_n low for exactly the one cycle that follows that edge.
- R3: data_oe is 0 for exactly the three cycles that follow the bus_avail_n pulse: the cycle before the release, the release cycle (two cycles after bus_avail_n), and the cycle after. It is 1 at all other times.
- R4: A release request sampled while a sequence is in progress (any state other than `ST_IDLE`) has no effect. A request held low is accepted at the first edge in `ST_IDLE`, so repeated grants are spaced five cycles apart.
- R5: A strobe sampled in the release cycle yields, in the next cycle, an event of kind 0 (normal) with evt_chan = bus_data_in[1:0], evt_type = bus_data_in[3:2] and evt_payload = bus_data_in[63:4].
- R6: A strobe sampled with rel_req_n high outside the release cycle yields an event of kind 1 (repeat) whose channel is the remembered channel. This includes a strobe one cycle too early.
- R7: A strobe and a release request sampled together outside the release cycle yield an event of kind 2 (direct) with channel 2, and they start no release sequence.
- R8: The remembered channel is updated by every normal event (to the descriptor channel) and every direct event (to 2), and never by a repeat event.
- R9: Each sampled strobe gives exactly one evt_valid pulse in the following cycle. No event appears without a strobe, and kind 3 never appears.
- R10: A strobe sampled in the release cycle while rel_req_n is also low is decoded as normal (R5), not as direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rel_req_n | input | 1 | Data-bus release request from the device, active low |
| xfer_req_n | input | 1 | Transfer-request strobe from the device, active low |
| bus_data_in | input | 64 | Data bus as seen by the controller, descriptor source |
| bus_avail_n | output | 1 | Bus-available pulse, active low, registered |
| data_oe | output | 1 | Enable for the controller's data-pin drivers, registered |
| evt_valid | output | 1 | Request event valid, one cycle |
| evt_kind | output | 2 | 0 normal, 1 repeat, 2 direct |
| evt_chan | output | 2 | Target channel of the event |
| evt_type | output | 2 | Request type from the descriptor (0 for other kinds) |
| evt_payload | output | 60 | Descriptor bits 63:4 (0 for other kinds) |

## Verification
On every cycle the assertions check several fixed timing relations:

- The bus-available pulse lasts one cycle.
- The blanking window lasts exactly three cycles and directly follows the pulse.
- No new grant appears within four cycles of the previous one.
- A normal event sits three cycles after a grant.
- Every event follows a strobe, and a direct event always names channel 2.

Some behaviours depend on the history of requests, and only the bench's scenarios against its reference model can show them. These include the value of the remembered channel after direct, normal and repeat events, the acceptance of a held release request exactly at the first idle edge, a strobe that arrives one cycle early, and the descriptor taking priority over the direct form in the release cycle.

// File: rtl/ddt_pkg.sv
package ddt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GRANT   = 3'd1,
        ST_PRE     = 3'd2,
        ST_RELEASE = 3'd3,
        ST_POST    = 3'd4
    } rel_state_e;

    typedef enum logic [1:0] {
        KIND_NORMAL = 2'd0,
        KIND_REPEAT = 2'd1,
        KIND_DIRECT = 2'd2
    } req_kind_e;

endpackage

// File: rtl/ddt_release_fsm.sv
module ddt_release_fsm
    import ddt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rel_req,
    input  logic strobe,
    output logic in_release,
    output logic bus_avail_n,
    output logic data_oe
);

    rel_state_e state_q;
    rel_state_e state_d;

    // Next-state logic: a release request combined with the strobe is a
    // direct request and does not open a release sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (rel_req && !strobe) state_d = ST_GRANT;
            ST_GRANT:   state_d = ST_PRE;
            ST_PRE:     state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_POST;
            ST_POST:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, derived from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_avail_n <= 1'b1;
            data_oe     <= 1'b1;
        end else begin
            bus_avail_n <= (state_d != ST_GRANT);
            data_oe     <= !(state_d inside {ST_PRE, ST_RELEASE, ST_POST});
        end
    end

    assign in_release = (state_q == ST_RELEASE);

endmodule

// File: rtl/ddt_req_decode.sv
module ddt_req_decode
    import ddt_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int CHAN_W      = 2,
    parameter int TYPE_W      = 2,
    parameter int DIRECT_CHAN = 2,
    localparam int PAY_W      = DATA_W - CHAN_W - TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_req,
    input  logic              strobe,
    input  logic              in_release,
    input  logic [DATA_W-1:0] bus_data,
    output logic              evt_valid,
    output logic [1:0]        evt_kind,
    output logic [CHAN_W-1:0] evt_chan,
    output logic [TYPE_W-1:0] evt_type,
    output logic [PAY_W-1:0]  evt_payload
);

    localparam int TYPE_LSB = CHAN_W;
    localparam int PAY_LSB  = CHAN_W + TYPE_W;
    localparam logic [CHAN_W-1:0] DIR_CH = CHAN_W'(DIRECT_CHAN);

    logic [CHAN_W-1:0] last_chan_q;

    wire is_normal = strobe && in_release;
    wire is_direct = strobe && !in_release && rel_req;
    wire is_repeat = strobe && !in_release && !rel_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_chan_q <= '0;
            evt_valid   <= 1'b0;
            evt_kind    <= KIND_NORMAL;
            evt_chan    <= '0;
            evt_type    <= '0;
            evt_payload <= '0;
        end else begin
            evt_valid   <= strobe;
            evt_type    <= '0;
            evt_payload <= '0;
            if (is_normal) begin
                evt_kind    <= KIND_NORMAL;
                evt_chan    <= bus_data[CHAN_W-1:0];
                evt_type    <= bus_data[TYPE_LSB +: TYPE_W];
                evt_payload <= bus_data[PAY_LSB +: PAY_W];
                last_chan_q <= bus_data[CHAN_W-1:0];
            end else if (is_direct) begin
                evt_kind    <= KIND_DIRECT;
                evt_chan    <= DIR_CH;
                last_chan_q <= DIR_CH;
            end else if (is_repeat) begin
                evt_kind    <= KIND_REPEAT;
                evt_chan    <= last_chan_q;
            end
        end
    end

endmodule

// File: rtl/ddt_bus_handshake.sv
module ddt_bus_handshake #(
    parameter int DATA_W      = 64,
    parameter int CHAN_W      = 2,
    parameter int TYPE_W      = 2,
    parameter int DIRECT_CHAN = 2,
    localparam int PAY_W      = DATA_W - CHAN_W - TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_req_n,
    input  logic              xfer_req_n,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              bus_avail_n,
    output logic              data_oe,
    output logic              evt_valid,
    output logic [1:0]        evt_kind,
    output logic [CHAN_W-1:0] evt_chan,
    output logic [TYPE_W-1:0] evt_type,
    output logic [PAY_W-1:0]  evt_payload
);

    logic rel_req;
    logic strobe;
    logic in_release;

    assign rel_req = !rel_req_n;
    assign strobe  = !xfer_req_n;

    ddt_release_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rel_req     (rel_req),
        .strobe      (strobe),
        .in_release  (in_release),
        .bus_avail_n (bus_avail_n),
        .data_oe     (data_oe)
    );

    ddt_req_decode #(
        .DATA_W      (DATA_W),
        .CHAN_W      (CHAN_W),
        .TYPE_W      (TYPE_W),
        .DIRECT_CHAN (DIRECT_CHAN)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .rel_req     (rel_req),
        .strobe      (strobe),
        .in_release  (in_release),
        .bus_data    (bus_data_in),
        .evt_valid   (evt_valid),
        .evt_kind    (evt_kind),
        .evt_chan    (evt_chan),
        .evt_type    (evt_type),
        .evt_payload (evt_payload)
    );

endmodule

// File: rtl/ddt_bus_handshake_chk.sv
module ddt_bus_handshake_chk #(
    parameter int CHAN_W      = 2,
    parameter int DIRECT_CHAN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_req_n,
    input logic              bus_avail_n,
    input logic              data_oe,
    input logic              evt_valid,
    input logic [1:0]        evt_kind,
    input logic [CHAN_W-1:0] evt_chan
);

    a_r2_avail_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_avail_n |=> bus_avail_n);

    a_r3_blank_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_avail_n |=> !data_oe);

    a_r3_blank_three_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_oe) |=> !data_oe ##1 !data_oe ##1 data_oe);

    a_r3_blank_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_oe) |-> $past(!bus_avail_n));

    a_r4_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_avail_n |=> bus_avail_n ##1 bus_avail_n ##1 bus_avail_n ##1 bus_avail_n);

    a_r5_normal_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd0) |-> ($past(!bus_avail_n, 3) && !data_oe));

    a_r7_direct_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd2) |-> (evt_chan == CHAN_W'(DIRECT_CHAN)));

    a_r9_event_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ($past(!xfer_req_n) && evt_kind != 2'd3));

endmodule

bind ddt_bus_handshake ddt_bus_handshake_chk #(
    .CHAN_W      (CHAN_W),
    .DIRECT_CHAN (DIRECT_CHAN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_req_n  (xfer_req_n),
    .bus_avail_n (bus_avail_n),
    .data_oe     (data_oe),
    .evt_valid   (evt_valid),
    .evt_kind    (evt_kind),
    .evt_chan    (evt_chan)
);

// File: tb/ddt_bus_handshake_tb.sv
module ddt_bus_handshake_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rel_req_n = 1'b1;
    logic        xfer_req_n = 1'b1;
    logic [63:0] bus_data_in = '0;
    logic        bus_avail_n, data_oe, evt_valid;
    logic [1:0]  evt_kind, evt_chan, evt_type;
    logic [59:0] evt_payload;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddt_bus_handshake u_dut (
        .clk(clk), .rst_n(rst_n), .rel_req_n(rel_req_n), .xfer_req_n(xfer_req_n),
        .bus_data_in(bus_data_in), .bus_avail_n(bus_avail_n), .data_oe(data_oe),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_chan(evt_chan),
        .evt_type(evt_type), .evt_payload(evt_payload)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 grant, 2..4 blanking (3 = release)
    int          m_phase;
    logic [1:0]  m_last;
    logic        m_valid;
    logic [1:0]  m_kind, m_chan, m_type;
    logic [59:0] m_pay;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase <= 0; m_last <= 2'd0; m_valid <= 1'b0;
            m_kind <= 2'd0; m_chan <= 2'd0; m_type <= 2'd0; m_pay <= '0;
        end else begin
            m_valid <= !xfer_req_n;
            m_type  <= 2'd0;
            m_pay   <= '0;
            if (!xfer_req_n && m_phase == 3) begin
                m_kind <= 2'd0; m_chan <= bus_data_in[1:0];
                m_type <= bus_data_in[3:2]; m_pay <= bus_data_in[63:4];
                m_last <= bus_data_in[1:0];
            end else if (!xfer_req_n && !rel_req_n) begin
                m_kind <= 2'd2; m_chan <= 2'd2; m_last <= 2'd2;
            end else if (!xfer_req_n) begin
                m_kind <= 2'd1; m_chan <= m_last;
            end
            if (m_phase == 0) m_phase <= (!rel_req_n && xfer_req_n) ? 1 : 0;
            else              m_phase <= (m_phase == 4) ? 0 : m_phase + 1;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(bus_avail_n == (m_phase != 1), "R2 bus_avail_n", 64'(bus_avail_n), 64'(m_phase != 1));
            chk(data_oe == !(m_phase >= 2), "R3 data_oe", 64'(data_oe), 64'(!(m_phase >= 2)));
            chk(evt_valid == m_valid, "R9 evt_valid", 64'(evt_valid), 64'(m_valid));
            if (m_valid) begin
                chk({evt_kind, evt_chan} == {m_kind, m_chan},
                    (m_kind == 2'd0) ? "R5 kind/chan" : (m_kind == 2'd1) ? "R6 kind/chan" : "R7 kind/chan",
                    64'({evt_kind, evt_chan}), 64'({m_kind, m_chan}));
                chk({evt_type, evt_payload} == {m_type, m_pay}, "R5 type/payload",
                    {evt_type, evt_payload}, {m_type, m_pay});
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int grants;
        int first_g;
        int second_g;
        tick(); tick();
        // R1: reset values
        chk(bus_avail_n && data_oe && !evt_valid, "R1 reset outputs",
            64'({bus_avail_n, data_oe, evt_valid}), 64'b110);
        rst_n = 1'b1;
        tick();

        // Normal sequence with descriptor (R2, R3, R5)
        rel_req_n = 1'b0; tick(); rel_req_n = 1'b1;
        chk(bus_avail_n == 1'b0, "R2 grant pulse", 64'(bus_avail_n), 64'd0);
        tick();
        chk(data_oe == 1'b0, "R3 blank before release", 64'(data_oe), 64'd0);
        tick();
        xfer_req_n = 1'b0; bus_data_in = 64'hABCD_0123_4567_89ED;
        tick(); xfer_req_n = 1'b1;
        chk(evt_valid && evt_kind == 2'd0 && evt_chan == 2'd1 && evt_type == 2'd3,
            "R5 normal descriptor", 64'({evt_kind, evt_chan, evt_type}), 64'b00_01_11);
        chk(evt_payload == 60'hABCD_0123_4567_89E, "R5 payload", 64'(evt_payload), 64'hABCD_0123_4567_89E);
        tick();
        chk(data_oe == 1'b1, "R3 blank ends", 64'(data_oe), 64'd1);

        // Repeat uses last channel (R6)
        tick(); xfer_req_n = 1'b0; tick(); xfer_req_n = 1'b1;
        chk(evt_valid && evt_kind == 2'd1 && evt_chan == 2'd1, "R6 repeat",
            64'({evt_kind, evt_chan}), 64'b01_01);

        // Direct: channel 2, no release (R7), then repeat follows it (R8)
        rel_req_n = 1'b0; xfer_req_n = 1'b0; tick(); rel_req_n = 1'b1; xfer_req_n = 1'b1;
        chk(evt_valid && evt_kind == 2'd2 && evt_chan == 2'd2 && bus_avail_n,
            "R7 direct", 64'({evt_kind, evt_chan, bus_avail_n}), 64'b10_10_1);
        tick();
        chk(bus_avail_n && data_oe, "R7 no sequence", 64'({bus_avail_n, data_oe}), 64'b11);
        xfer_req_n = 1'b0; tick(); xfer_req_n = 1'b1;
        chk(evt_kind == 2'd2 - 2'd1 && evt_chan == 2'd2, "R8 last after direct",
            64'({evt_kind, evt_chan}), 64'b01_10);

        // Held release request, with strobe in release cycle (R4, R10)
        grants = 0; first_g = 0; second_g = 0;
        rel_req_n = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            tick();
            if (!bus_avail_n) begin
                grants++;
                if (grants == 1) first_g = i; else second_g = i;
            end
            if (i == 3) begin xfer_req_n = 1'b0; bus_data_in = 64'h3; end
            if (i == 4) begin
                xfer_req_n = 1'b1;
                chk(evt_valid && evt_kind == 2'd0 && evt_chan == 2'd3, "R10 descriptor wins",
                    64'({evt_kind, evt_chan}), 64'b00_11);
            end
            if (i == 10) rel_req_n = 1'b1;
        end
        chk(grants == 2 && second_g - first_g == 5, "R4 held request spacing",
            64'(second_g - first_g), 64'd5);
        tick(); tick();

        // Strobe one cycle early is a repeat (R6)
        rel_req_n = 1'b0; tick(); rel_req_n = 1'b1;
        tick(); xfer_req_n = 1'b0; tick(); xfer_req_n = 1'b1;
        chk(evt_valid && evt_kind == 2'd1 && evt_chan == 2'd3, "R6 early strobe",
            64'({evt_kind, evt_chan}), 64'b01_11);
        repeat (5) tick();

        // Reset mid-run clears remembered channel (R1, R8)
        rst_n = 1'b0; tick();
        chk(bus_avail_n && data_oe && !evt_valid, "R1 reset again",
            64'({bus_avail_n, data_oe, evt_valid}), 64'b110);
        rst_n = 1'b1; tick();
        xfer_req_n = 1'b0; tick(); xfer_req_n = 1'b1;
        chk(evt_kind == 2'd1 && evt_chan == 2'd0, "R8 last after reset",
            64'({evt_kind, evt_chan}), 64'b01_00);

        // Random traffic, compared against the reference every cycle
        for (int i = 0; i < 400; i++) begin
            tick();
            rel_req_n   = ($urandom_range(0, 3) != 0);
            xfer_req_n  = ($urandom_range(0, 2) != 0);
            bus_data_in = {$urandom, $urandom};
        end
        tick(); rel_req_n = 1'b1; xfer_req_n = 1'b1;
        repeat (6) tick();
        finish_run();
    end

endmodule